// File: doc/BRIEF.md
# Automatic Busy Redial Controller

This block is the control sequencer that automates busy redialing for a telephone dialer. A tone decoder that is not part of this block presents a small set of decoded line events: a dial tone level, a ringback level, a general line-signal level and a per-window busy verdict. From these events the controller decides when to press the dialer's redial key, when to hang up, how long to stay on-hook, and when to give up.

A falling edge on the request pin arms the controller, and the next falling edge disarms it. While the controller is armed it holds the line off-hook and waits for dial tone. On dial tone it fires one redial-key pulse and then watches the line. If the line shows a busy condition, stays silent too long, or returns a dial tone that persists, the controller hangs up for a break time chosen by the select pins and then starts a new attempt. After a selectable number of breaks, or after the far end has rung back 30 times in one attempt, the controller emits an end pulse and returns to idle. A slow, low-duty activity clock drives an indicator LED while the controller is armed. Every duration is a parameter counted in ticks of the 32768 Hz clock.

Top module: `abr_redial_ctrl`

## Requirements
- R1: While `hook_off` is low, a falling edge on `req_n` while idle arms the controller and raises `brk` (off-hook) on the next cycle. A falling edge while armed returns the controller to idle with `brk` low and no end pulse.
- R2: While the controller is armed, `led` is a clock of period `LED_T` ticks that is high for `LED_T/4` ticks of each period. `led` is low while the controller is idle.
- R3: In the waiting-for-dial state, a high `dial_tone` produces exactly one `key_pulse` of `KEY_T` ticks. Dial tone seen later in the same attempt causes no further key pulse.
- R4: After the key press, `BUSY_WINS` (3) consecutive window strobes (`win_done`) with `busy_hit` high start a break. A strobe with `busy_hit` low restarts that run from zero.
- R5: After the key press, `line_sig` low for `SIL_T` consecutive ticks starts a break.
- R6: After the key press, `dial_tone` high for `STUCK_T` consecutive ticks starts a break.
- R7: A break holds `brk` low for a number of ticks set by `sel` latched at arming: 00 and 10 give `BRK_LONG_T`, 01 gives `BRK_MID_T`, 11 gives `BRK_SHORT_T`. If the repeat limit is not yet reached, `brk` then returns high and a new attempt waits for dial tone.
- R8: The repeat limit set by `sel` is 10 for 00 and 01, 3 for 10 and 15 for 11. When the break with that number ends, `end_pulse` goes high for `END_T` ticks and the controller becomes idle.
- R9: Within one attempt, the `RB_LIMIT` (30) rising edge of `ringback` after the key press drops `brk`, fires an `END_T` end pulse and returns to idle. The ringback count restarts with every new attempt.
- R10: After reset, `brk`, `key_pulse`, `led` and `end_pulse` are all low.
- R11: While `hook_off` is high, the controller is forced idle (`brk` and `led` low) and request edges are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Toggle request, acts on its falling edge |
| hook_off | input | 1 | Handset off-hook sense, high forces idle |
| sel | input | 2 | Repeat count and break time select |
| dial_tone | input | 1 | Decoded dial tone present |
| ringback | input | 1 | Decoded ringback tone present |
| line_sig | input | 1 | Any in-band line signal present |
| win_done | input | 1 | One-tick strobe at the end of a decode window |
| busy_hit | input | 1 | Window verdict busy or reorder, read with win_done |
| brk | output | 1 | Hook control, high off-hook, low on-hook |
| key_pulse | output | 1 | Redial key trigger pulse |
| led | output | 1 | Activity indicator clock |
| end_pulse | output | 1 | Sequence finished pulse |

## Verification
The hardest state to reach from the ports is the last break of a long repeat sequence. Every earlier attempt has to be walked through with a dial tone, a key press and a busy run, so that the attempt counter reaches the limit for the selected code. The bench walks each select code through its full loop from a table of repeat counts and break lengths. It measures every break and checks that the end pulse comes only after the last one. A second case, the ringback count restarting at a new attempt, is reached by spending 20 ringback edges in one attempt, forcing a break, and then checking that 29 edges in the next attempt do not end the sequence.

// File: rtl/abr_pkg.sv
package abr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MON  = 2'd2,
        ST_BRK  = 2'd3
    } abr_state_e;

    typedef struct packed {
        logic [3:0] rep_lim;
        logic [1:0] brk_sel;
    } abr_cfg_t;

    function automatic logic [3:0] rep_limit(input logic [1:0] code);
        case (code)
            2'b10:   rep_limit = 4'd3;
            2'b11:   rep_limit = 4'd15;
            default: rep_limit = 4'd10;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic int cw(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/abr_pulse_gen.sv
module abr_pulse_gen #(
    parameter int LEN = 3277
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic trig,
    output logic q
);
    localparam int W = abr_pkg::cw(LEN + 1);
    localparam logic [W-1:0] LOAD = W'(LEN);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign q = (cnt != '0);

    assert_pulse_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (trig && !clr) |=> q);

endmodule

// File: rtl/abr_led_gen.sv
module abr_led_gen #(
    parameter int PERIOD = 38102
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic led
);
    localparam int W = abr_pkg::cw(PERIOD);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);
    localparam logic [W-1:0] HIGH = W'(PERIOD / 4);

    logic [W-1:0] phase;
    logic         on;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase <= '0;
            on    <= 1'b0;
        end else begin
            on    <= 1'b1;
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign led = on && (phase < HIGH);

    assert_led_dark_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> !led);

endmodule

// File: rtl/abr_line_monitor.sv
module abr_line_monitor #(
    parameter int SIL_T     = 989594,
    parameter int STUCK_T   = 229376,
    parameter int BUSY_WINS = 3,
    parameter int RB_LIMIT  = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic dial_tone,
    input  logic line_sig,
    input  logic win_done,
    input  logic busy_hit,
    input  logic ringback,
    output logic trip,
    output logic rb_done
);
    localparam int SW = abr_pkg::cw(SIL_T);
    localparam int DW = abr_pkg::cw(STUCK_T);
    localparam int BW = abr_pkg::cw(BUSY_WINS);
    localparam int RW = abr_pkg::cw(RB_LIMIT);
    localparam logic [SW-1:0] SIL_LAST  = SW'(SIL_T - 1);
    localparam logic [DW-1:0] DIAL_LAST = DW'(STUCK_T - 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_WINS - 1);
    localparam logic [RW-1:0] RB_LAST   = RW'(RB_LIMIT - 1);

    logic [SW-1:0] sil_cnt;
    logic [DW-1:0] dial_cnt;
    logic [BW-1:0] busy_run;
    logic [RW-1:0] rb_cnt;
    logic          rb_prev;
    logic          rb_rise;
    logic          trip_sil, trip_dial, trip_busy;

    assign rb_rise   = ringback && !rb_prev;
    assign trip_sil  = arm && !line_sig && (sil_cnt == SIL_LAST);
    assign trip_dial = arm && dial_tone && (dial_cnt == DIAL_LAST);
    assign trip_busy = arm && win_done && busy_hit && (busy_run == BUSY_LAST);
    assign trip      = trip_sil || trip_dial || trip_busy;
    assign rb_done   = arm && rb_rise && (rb_cnt == RB_LAST);

    always_ff @(posedge clk) begin
        if (rst) rb_prev <= 1'b0;
        else     rb_prev <= ringback;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm || line_sig) sil_cnt <= '0;
        else if (sil_cnt != SIL_LAST) sil_cnt <= sil_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm || !dial_tone) dial_cnt <= '0;
        else if (dial_cnt != DIAL_LAST) dial_cnt <= dial_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            busy_run <= '0;
        end else if (win_done) begin
            if (!busy_hit || busy_run == BUSY_LAST) busy_run <= '0;
            else                                   busy_run <= busy_run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) rb_cnt <= '0;
        else if (rb_rise && rb_cnt != RB_LAST) rb_cnt <= rb_cnt + 1'b1;
    end

    assert_busy_run_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BUSY_LAST);

    assert_rb_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (rb_cnt == '0));

endmodule

// File: rtl/abr_redial_ctrl.sv
module abr_redial_ctrl #(
    parameter int KEY_T       = 3277,
    parameter int END_T       = 3277,
    parameter int LED_T       = 38102,
    parameter int SIL_T       = 989594,
    parameter int STUCK_T     = 229376,
    parameter int BRK_LONG_T  = 2057830,
    parameter int BRK_MID_T   = 1068237,
    parameter int BRK_SHORT_T = 152371,
    parameter int BUSY_WINS   = 3,
    parameter int RB_LIMIT    = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_n,
    input  logic       hook_off,
    input  logic [1:0] sel,
    input  logic       dial_tone,
    input  logic       ringback,
    input  logic       line_sig,
    input  logic       win_done,
    input  logic       busy_hit,
    output logic       brk,
    output logic       key_pulse,
    output logic       led,
    output logic       end_pulse
);
    import abr_pkg::*;

    localparam int TW = cw(max3(BRK_LONG_T, BRK_MID_T, BRK_SHORT_T));
    localparam logic [TW-1:0] LONG_LAST  = TW'(BRK_LONG_T - 1);
    localparam logic [TW-1:0] MID_LAST   = TW'(BRK_MID_T - 1);
    localparam logic [TW-1:0] SHORT_LAST = TW'(BRK_SHORT_T - 1);

    abr_state_e    state;
    abr_cfg_t      cfg;
    logic [3:0]    attempts;
    logic [TW-1:0] brk_cnt;
    logic [TW-1:0] brk_last;
    logic          req_q;
    logic          req_fall;
    logic          trip, rb_done;
    logic          brk_done, limit_hit;
    logic          key_fire, end_fire;

    assign req_fall  = req_q && !req_n;
    assign brk_done  = (brk_cnt == brk_last);
    assign limit_hit = (attempts >= cfg.rep_lim);

    always_comb begin
        case (cfg.brk_sel)
            2'b01:   brk_last = MID_LAST;
            2'b11:   brk_last = SHORT_LAST;
            default: brk_last = LONG_LAST;
        endcase
    end

    assign key_fire = !hook_off && !req_fall && (state == ST_WAIT) && dial_tone;
    assign end_fire = !hook_off && !req_fall &&
                      (((state == ST_MON) && rb_done) ||
                       ((state == ST_BRK) && brk_done && limit_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '0;
            attempts <= '0;
            brk_cnt  <= '0;
            req_q    <= 1'b1;
        end else begin
            req_q <= req_n;
            if (hook_off) begin
                state    <= ST_IDLE;
                attempts <= '0;
                brk_cnt  <= '0;
            end else if (req_fall) begin
                brk_cnt <= '0;
                if (state == ST_IDLE) begin
                    state    <= ST_WAIT;
                    cfg      <= '{rep_lim: rep_limit(sel), brk_sel: sel};
                    attempts <= '0;
                end else begin
                    state <= ST_IDLE;
                end
            end else begin
                case (state)
                    ST_WAIT: if (dial_tone) state <= ST_MON;
                    ST_MON: begin
                        if (rb_done) begin
                            state <= ST_IDLE;
                        end else if (trip) begin
                            state    <= ST_BRK;
                            attempts <= attempts + 1'b1;
                            brk_cnt  <= '0;
                        end
                    end
                    ST_BRK: begin
                        if (brk_done) begin
                            brk_cnt <= '0;
                            state   <= limit_hit ? ST_IDLE : ST_WAIT;
                        end else begin
                            brk_cnt <= brk_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign brk = (state == ST_WAIT) || (state == ST_MON);

    abr_line_monitor #(
        .SIL_T(SIL_T), .STUCK_T(STUCK_T), .BUSY_WINS(BUSY_WINS), .RB_LIMIT(RB_LIMIT)
    ) u_mon (
        .clk(clk), .rst(rst), .arm(state == ST_MON),
        .dial_tone(dial_tone), .line_sig(line_sig), .win_done(win_done),
        .busy_hit(busy_hit), .ringback(ringback), .trip(trip), .rb_done(rb_done)
    );

    abr_pulse_gen #(.LEN(KEY_T)) u_key (
        .clk(clk), .rst(rst), .clr(hook_off), .trig(key_fire), .q(key_pulse)
    );

    abr_pulse_gen #(.LEN(END_T)) u_end (
        .clk(clk), .rst(rst), .clr(hook_off), .trig(end_fire), .q(end_pulse)
    );

    abr_led_gen #(.PERIOD(LED_T)) u_led (
        .clk(clk), .rst(rst), .active(state != ST_IDLE), .led(led)
    );

    assert_hook_forces_idle_R11: assert property (@(posedge clk) disable iff (rst)
        hook_off |=> (state == ST_IDLE));

    assert_key_from_wait_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(key_pulse) |-> ($past(state) == ST_WAIT));

    assert_end_means_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(end_pulse) |-> (state == ST_IDLE));

    assert_break_timer_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BRK) |-> (brk_cnt <= brk_last));

endmodule

// File: tb/abr_redial_ctrl_tb.sv
`timescale 1ns/1ps
module abr_redial_ctrl_tb;
    localparam int KEY_T = 4, END_T = 5, LED_T = 16, SIL_T = 40, STUCK_T = 30;
    localparam int BL = 20, BM = 12, BS = 6;

    localparam int ROW_SEL [4] = '{0, 1, 2, 3};
    localparam int ROW_REP [4] = '{10, 10, 3, 15};
    localparam int ROW_BRK [4] = '{BL, BM, BL, BS};

    logic clk = 0, rst = 1, req_n = 1, hook_off = 0;
    logic [1:0] sel = 0;
    logic dial_tone = 0, ringback = 0, line_sig = 1, win_done = 0, busy_hit = 0;
    logic brk, key_pulse, led, end_pulse;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    abr_redial_ctrl #(
        .KEY_T(KEY_T), .END_T(END_T), .LED_T(LED_T), .SIL_T(SIL_T), .STUCK_T(STUCK_T),
        .BRK_LONG_T(BL), .BRK_MID_T(BM), .BRK_SHORT_T(BS), .BUSY_WINS(3), .RB_LIMIT(30)
    ) u_dut (
        .clk(clk), .rst(rst), .req_n(req_n), .hook_off(hook_off), .sel(sel),
        .dial_tone(dial_tone), .ringback(ringback), .line_sig(line_sig),
        .win_done(win_done), .busy_hit(busy_hit),
        .brk(brk), .key_pulse(key_pulse), .led(led), .end_pulse(end_pulse)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        req_n = 0; step();
        req_n = 1; step();
    endtask

    task automatic press(output int kc);
        dial_tone = 1; step();
        dial_tone = 0;
        kc = 0;
        repeat (KEY_T + 2) begin
            if (key_pulse) kc++;
            step();
        end
    endtask

    task automatic window(input logic hit);
        win_done = 1; busy_hit = hit; step();
        win_done = 0; busy_hit = 0; step();
    endtask

    task automatic rb_edges(input int n);
        repeat (n) begin
            ringback = 1; step();
            ringback = 0; step();
        end
    endtask

    task automatic settle();
        repeat (END_T + 3) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int kc, c, breaks, bad;
        step(); step(); rst = 0; step();

        // R10 reset state
        chk("R10 brk", brk, 0); chk("R10 key", key_pulse, 0);
        chk("R10 led", led, 0); chk("R10 end", end_pulse, 0);

        // Table walk: every select code through its full redial loop (R7, R8, R3)
        for (int r = 0; r < 4; r++) begin
            sel = 2'(ROW_SEL[r]);
            pulse_req();
            breaks = 0; bad = 0;
            while (!end_pulse && breaks < 20) begin
                if (!brk) bad++;
                press(kc);
                if (kc != KEY_T) bad++;
                window(1); window(1); window(1);
                c = 1;
                while (!brk && !end_pulse && c < 1000) begin c++; step(); end
                if (c != ROW_BRK[r]) bad++;
                breaks++;
            end
            chk("R7 break lengths and key pulses per row", bad, 0);
            chk("R8 repeat count", breaks, ROW_REP[r]);
            c = 0;
            while (end_pulse && c < 100) begin c++; step(); end
            chk("R8 end pulse width", c, END_T);
            chk("R8 idle after end", brk, 0);
            settle();
        end
        sel = 0;

        // R1 toggle on and off
        pulse_req(); chk("R1 armed brk high", brk, 1);
        // R2 LED duty
        step(); step(); c = 0;
        repeat (2 * LED_T) begin if (led) c++; step(); end
        chk("R2 led high ticks", c, 2 * (LED_T / 4));
        pulse_req(); chk("R1 disarm brk low", brk, 0);
        c = 0;
        repeat (LED_T) begin if (led || end_pulse) c++; step(); end
        chk("R2 led and end quiet when idle", c, 0);

        // R3 later dial tone ignored, R6 stuck dial tone
        pulse_req(); press(kc); chk("R3 key width", kc, KEY_T);
        dial_tone = 1; c = 0; kc = 0;
        while (brk && c < 200) begin step(); c++; if (key_pulse) kc++; end
        dial_tone = 0;
        chk("R6 stuck dial to break", c, STUCK_T);
        chk("R3 no second key pulse", kc, 0);
        pulse_req(); settle();

        // R5 silence
        pulse_req(); press(kc);
        line_sig = 0; c = 0;
        while (brk && c < 200) begin step(); c++; end
        line_sig = 1;
        chk("R5 silence to break", c, SIL_T);
        pulse_req(); settle();

        // R4 non-successive busy windows
        pulse_req(); press(kc);
        window(1); window(1); window(0); window(1); window(1);
        chk("R4 broken run keeps line", brk, 1);
        window(1);
        chk("R4 third successive busy breaks", brk, 0);
        pulse_req(); settle();

        // R9 ringback count restarts per attempt, then limit
        sel = 2'b11;
        pulse_req(); press(kc);
        rb_edges(20);
        window(1); window(1); window(1);
        c = 0; while (!brk && c < 100) begin step(); c++; end
        press(kc);
        rb_edges(29);
        chk("R9 29 edges keep line", brk, 1);
        chk("R9 no early end", end_pulse, 0);
        ringback = 1; step();
        chk("R9 thirtieth edge ends", end_pulse, 1);
        chk("R9 hang up", brk, 0);
        ringback = 0; settle();
        sel = 0;

        // R11 hook_off
        pulse_req(); chk("R11 armed", brk, 1);
        hook_off = 1; step();
        chk("R11 forced idle", brk, 0);
        pulse_req(); chk("R11 request ignored", brk, 0);
        chk("R11 led low", led, 0);
        hook_off = 0; step();
        chk("R11 stays idle after release", brk, 0);
        pulse_req(); chk("R11 rearm works", brk, 1);
        pulse_req();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule